// File: doc/BRIEF.md
# NAND Hamming ECC Checker-Corrector

This block settles one 512-byte chunk of a NAND page. It takes the three-byte Hamming code kept in the spare area and the three-byte code computed over the chunk as it was read back. It rearranges both into a 32-bit word and XORs the two words into a syndrome. It then sorts the outcome into four classes: clean, repaired, code damaged or beyond repair. A separate flag marks a page that has never been programmed.

When the syndrome points at one flipped data bit, the block repairs the byte in a local 512-byte buffer. It does this through a simple synchronous memory port: one read of the byte, then one write of that byte with the bit inverted. For every other outcome the buffer is left alone. A single-cycle done pulse closes each check. The status, the erased flag and the repaired location stay on the outputs until the next accepted start.

Top module: `hecc_fix`

## Requirements
- R1: Each 24-bit code (byte 0 = bits 7:0, byte 1 = bits 15:8, byte 2 = bits 23:16) is unpacked to 32 bits. Byte 0 goes to bits 7:0, byte 1 to bits 23:16, the high nibble of byte 2 to bits 27:24 and the low nibble of byte 2 to bits 11:8. Every other bit is zero. The syndrome is the XOR of the two unpacked words. A zero syndrome gives status 0 with no memory write, and done rises in the first cycle after the start edge.
- R2: A syndrome with exactly 12 ones gives status 1, fix_byte = syndrome bits 27:19 and fix_bit = syndrome bits 18:16. For any other status, both fix outputs are zero.
- R3: For status 1, the block reads buffer byte fix_byte in the first cycle after start. In the next cycle it writes back that byte with bit fix_bit inverted. Done rises in the third cycle after the start edge, and exactly one write occurs.
- R4: A syndrome with exactly one set bit gives status 2, with no memory access and done in the first cycle.
- R5: Any other nonzero syndrome gives status 3, with no memory access. The one exception is the erased pattern of R6.
- R6: If the unpacked stored code is 0x0FFF0FFF and the unpacked computed code is 0, the result is status 0 with erased = 1 and no memory access. In every other case erased is 0.
- R7: A start that arrives while a repair is in progress is ignored. It does not change the outputs, cause a write or add a done pulse.
- R8: A synchronous reset clears done, status, erased, fix_byte, fix_bit and both memory enables.
- R9: Done is high for a single cycle. The status and location outputs keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a check with the codes present this cycle |
| ecc_stored | input | 24 | Code read from the spare area |
| ecc_calc | input | 24 | Code computed over the data chunk |
| mem_addr | output | 9 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe; data is returned in the next cycle |
| mem_rdata | input | 8 | Buffer read data |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean or erased, 1 repaired, 2 code damaged, 3 uncorrectable |
| erased | output | 1 | Erased-page pattern recognised |
| fix_byte | output | 9 | Index of the repaired byte |
| fix_bit | output | 3 | Bit position of the repaired bit |

## Verification
The assertions assume that the buffer behaves as a one-cycle synchronous read memory. They also assume that, during a repair, nothing but the block writes to the buffer. The buffer model in the bench keeps to both: it answers every read on the next edge, and the bench never writes to it while a check runs.

The assertions also take start and the code inputs as driven away from the clock edge. The bench changes them only on the falling edge. The codes only need to be valid in the start cycle, and the bench holds them there for a full cycle.

// File: rtl/hecc_fix.sv
module hecc_fix (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [23:0] ecc_stored,
  input  logic [23:0] ecc_calc,
  output logic [8:0]  mem_addr,
  output logic        mem_rd_en,
  input  logic [7:0]  mem_rdata,
  output logic        mem_wr_en,
  output logic [7:0]  mem_wdata,
  output logic        done,
  output logic [1:0]  status,
  output logic        erased,
  output logic [8:0]  fix_byte,
  output logic [2:0]  fix_bit
);
  localparam logic [1:0]  ST_CLEAN  = 2'd0;
  localparam logic [1:0]  ST_FIXED  = 2'd1;
  localparam logic [1:0]  ST_BADECC = 2'd2;
  localparam logic [1:0]  ST_UNCORR = 2'd3;
  localparam logic [31:0] ERASED_PAT = 32'h0FFF0FFF;
  localparam int          PAIR_BITS = 12;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} st_t;
  st_t st;

  wire [31:0] u_st = {4'h0, ecc_stored[23:20], ecc_stored[15:8], 4'h0, ecc_stored[19:16], ecc_stored[7:0]};
  wire [31:0] u_cc = {4'h0, ecc_calc[23:20],   ecc_calc[15:8],   4'h0, ecc_calc[19:16],   ecc_calc[7:0]};
  wire [31:0] syn  = u_st ^ u_cc;

  logic [5:0] pop;
  always_comb begin
    pop = '0;
    for (int i = 0; i < 12; i++) pop = pop + {5'd0, syn[i]} + {5'd0, syn[16+i]};
  end

  logic [1:0] cls;
  logic       era;
  always_comb begin
    era = 1'b0;
    if (syn == '0)                                   cls = ST_CLEAN;
    else if (pop == 6'(PAIR_BITS))                   cls = ST_FIXED;
    else if (pop == 6'd1)                            cls = ST_BADECC;
    else if (u_st == ERASED_PAT && u_cc == '0) begin cls = ST_CLEAN; era = 1'b1; end
    else                                             cls = ST_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      done     <= 1'b0;
      status   <= ST_CLEAN;
      erased   <= 1'b0;
      fix_byte <= '0;
      fix_bit  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          status   <= cls;
          erased   <= era;
          fix_byte <= (cls == ST_FIXED) ? syn[27:19] : 9'd0;
          fix_bit  <= (cls == ST_FIXED) ? syn[18:16] : 3'd0;
          if (cls == ST_FIXED) st <= S_READ;
          else                 done <= 1'b1;
        end
        S_READ:  st <= S_WRITE;
        S_WRITE: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = fix_byte;
  assign mem_rd_en = (st == S_READ);
  assign mem_wr_en = (st == S_WRITE);
  assign mem_wdata = mem_rdata ^ (8'h01 << fix_bit);
endmodule

// File: rtl/hecc_fix_chk.sv
module hecc_fix_chk (
  input logic       clk,
  input logic       rst,
  input logic [8:0] mem_addr,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic       done,
  input logic [1:0] status,
  input logic       erased,
  input logic [8:0] fix_byte,
  input logic [2:0] fix_bit
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> mem_wr_en); // R3
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> $past(mem_rd_en)); // R3
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd_en && mem_wr_en)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> $stable(mem_addr)); // R3
  AST_ACCESS_ONLY_FIX: assert property (@(posedge clk) disable iff (rst) (mem_rd_en || mem_wr_en) |-> status == 2'd1); // R4
  AST_ERASED_CLEAN: assert property (@(posedge clk) disable iff (rst) erased |-> status == 2'd0); // R6
  AST_FIX_ZERO: assert property (@(posedge clk) disable iff (rst) (status != 2'd1) |-> (fix_byte == 9'd0 && fix_bit == 3'd0)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done && !mem_wr_en && !mem_rd_en && !erased)); // R8
endmodule

bind hecc_fix hecc_fix_chk u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .done(done), .status(status), .erased(erased), .fix_byte(fix_byte), .fix_bit(fix_bit)
);

// File: tb/hecc_fix_bench.sv
module hecc_fix_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] ecc_stored = '0;
  logic [23:0] ecc_calc = '0;
  logic [8:0]  mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        done, erased;
  logic [1:0]  status;
  logic [8:0]  fix_byte;
  logic [2:0]  fix_bit;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  bit finished = 1'b0;

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  hecc_fix u_hecc_fix (
    .clk(clk), .rst(rst), .start(start), .ecc_stored(ecc_stored), .ecc_calc(ecc_calc),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done), .status(status),
    .erased(erased), .fix_byte(fix_byte), .fix_bit(fix_bit)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) ^ (i >> 3) ^ 8'hA5);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) mem[i] <= pat(i);
      mem_rdata <= '0;
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr];
      if (mem_wr_en) begin
        mem[mem_addr] <= mem_wdata;
        wr_count <= wr_count + 1;
      end
    end
  end

  // 32-bit syndrome layout -> 24-bit code difference
  function automatic logic [23:0] pack(logic [31:0] u);
    return {u[27:24], u[11:8], u[23:16], u[7:0]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one check: pulse start, measure latency to done, compare outputs and writes
  task automatic run(logic [23:0] s, logic [23:0] c, logic [1:0] es, bit ee,
                     logic [8:0] eb, logic [2:0] ebit, int elat, string req);
    int lat = 0;
    int w0 = wr_count;
    @(negedge clk);
    ecc_stored = s; ecc_calc = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == elat, req, "done latency", lat, elat);
    check(status == es && erased == ee, req, "status/erased", {status, erased}, {es, ee});
    check(fix_byte == eb && fix_bit == ebit, req, "fix location", {fix_byte, fix_bit}, {eb, ebit});
    check(wr_count - w0 == (es == 2'd1 ? 1 : 0), req, "write count", wr_count - w0, (es == 2'd1 ? 1 : 0));
    if (es == 2'd1) begin
      exp_mem[eb] = exp_mem[eb] ^ (8'h01 << ebit);
      check(mem[eb] == exp_mem[eb], req, "repaired byte", mem[eb], exp_mem[eb]);
    end
  endtask

  task automatic t_reset();
    check(!done && status == 2'd0 && !erased && !mem_wr_en && !mem_rd_en && fix_byte == 0 && fix_bit == 0,
          "R8", "reset state", {done, status, erased, mem_wr_en, mem_rd_en}, 0);
  endtask

  task automatic t_clean();
    run(24'h3C5A96, 24'h3C5A96, 2'd0, 1'b0, 9'd0, 3'd0, 1, "R1");
    run(24'h000000, 24'h000000, 2'd0, 1'b0, 9'd0, 3'd0, 1, "R1");
  endtask

  task automatic t_all_single();
    for (int b = 0; b < 512; b++) begin
      for (int k = 0; k < 8; k++) begin
        logic [11:0] code = {9'(b), 3'(k)};
        logic [31:0] syn = {4'h0, code, 4'h0, ~code};
        logic [23:0] s = 24'(b * 24'h010203) ^ 24'h5A3C81;
        run(s, s ^ pack(syn), 2'd1, 1'b0, 9'(b), 3'(k), 3, "R2_R3");
      end
    end
  endtask

  task automatic t_ecc_bit();
    for (int k = 0; k < 24; k++)
      run(24'h81C3E7, 24'h81C3E7 ^ (24'h1 << k), 2'd2, 1'b0, 9'd0, 3'd0, 1, "R4");
  endtask

  task automatic t_double();
    run(24'h123456, 24'h123456 ^ 24'h000003, 2'd3, 1'b0, 9'd0, 3'd0, 1, "R5");
    run(24'h123456, 24'h123456 ^ 24'h800001, 2'd3, 1'b0, 9'd0, 3'd0, 1, "R5");
    run(24'h123456, 24'h123456 ^ 24'h001FFF, 2'd3, 1'b0, 9'd0, 3'd0, 1, "R5");
    run(24'hFFFFFF, 24'h000100, 2'd3, 1'b0, 9'd0, 3'd0, 1, "R5");
    run(24'h000000, 24'hFFFFFF, 2'd3, 1'b0, 9'd0, 3'd0, 1, "R5");
  endtask

  task automatic t_erased();
    run(24'hFFFFFF, 24'h000000, 2'd0, 1'b1, 9'd0, 3'd0, 1, "R6");
    run(24'hFFFFFF, 24'hFFFFFF, 2'd0, 1'b0, 9'd0, 3'd0, 1, "R6");
  endtask

  task automatic t_busy();
    logic [11:0] code = {9'd300, 3'd5};
    logic [23:0] s = 24'h0F0F0F;
    int w0 = wr_count;
    int dones = 0;
    @(negedge clk);
    ecc_stored = s; ecc_calc = s ^ pack({4'h0, code, 4'h0, ~code}); start = 1'b1;
    @(negedge clk);
    ecc_stored = 24'h0; ecc_calc = 24'h3;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    exp_mem[300] = exp_mem[300] ^ 8'h20;
    check(dones == 1, "R7", "done pulses", dones, 1);
    check(status == 2'd1 && fix_byte == 9'd300 && fix_bit == 3'd5, "R7", "outputs kept",
          {status, fix_byte, fix_bit}, {2'd1, 9'd300, 3'd5});
    check(wr_count - w0 == 1, "R7", "write count", wr_count - w0, 1);
    check(mem[300] == exp_mem[300], "R7", "repaired byte", mem[300], exp_mem[300]);
  endtask

  task automatic t_hold();
    run(24'h123456, 24'h123457, 2'd2, 1'b0, 9'd0, 3'd0, 1, "R9");
    @(negedge clk);
    check(!done, "R9", "done dropped", done, 0);
    repeat (3) @(negedge clk);
    check(status == 2'd2 && !done, "R9", "status held", {status, done}, {2'd2, 1'b0});
  endtask

  task automatic t_reset_mid();
    logic [11:0] code = {9'd7, 3'd1};
    @(negedge clk);
    ecc_stored = 24'h0; ecc_calc = pack({4'h0, code, 4'h0, ~code}); start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!done && status == 2'd0 && !mem_wr_en && !mem_rd_en && fix_byte == 0,
          "R8", "reset mid repair", {done, status, mem_wr_en, mem_rd_en}, 0);
    repeat (3) @(negedge clk);
    check(!done && mem[7] == pat(7), "R8", "no late write", mem[7], pat(7));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) exp_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_clean();
    t_all_single();
    t_ecc_bit();
    t_double();
    t_erased();
    t_busy();
    t_hold();
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (mem[i] != exp_mem[i]) bad++;
      check(bad == 0, "R3", "whole buffer", bad, 0);
    end
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule